// File: doc/BRIEF.md
# Bit-Serial Systolic Shift-Add Multiplier

This block multiplies two unsigned operands of `OPW` bits each and returns the full `2*OPW`-bit product. It is built as a linear chain of one-bit cells. The multiplier operand is consumed most significant digit first, and each step applies the update "double the partial product, then add digit times the multiplicand". The partial product starts at zero. Each digit travels up the chain through a register in every cell, so cell `j` applies digit step `k` in slot `k + j`. The carry a cell produces is consumed by the cell above it one slot later, together with the bit that cell held before the current step. The work therefore moves through the chain as a skewed wavefront, and no carry propagates across the word in a single cycle.

A caller presents both operands in parallel and pulses `start` while `busy` is low. The operands are captured on that edge. Exactly `3*OPW` edges later `done` pulses for one cycle. In the same cycle the product starts to leave on a one-bit stream. The stream uses a valid/ready handshake: a beat transfers on any edge where `res_valid` and `res_ready` are both high. While `res_ready` is low the stream holds its current beat unchanged, and the sink may stall for any number of cycles. No new operation is accepted until the last beat has transferred.

Top module: `shiftadd_systolic_mul`

## Requirements
- R1: During and after reset, `busy`, `done`, `res_valid` and `res_last` are low.
- R2: The streamed result equals the unsigned product `op_a * op_b`, `2*OPW` bits wide. Bit 0 of the product is sent first and bit `2*OPW-1` is sent last.
- R3: `done` is high for exactly one cycle. It becomes visible after the `3*OPW`-th rising edge that follows the edge accepting `start`.
- R4: A `start` pulse while `busy` is high is ignored: the running operation keeps its latency and its result.
- R5: The stream opens in the cycle where `done` is high. It carries exactly `2*OPW` beats, and `res_last` is high on the final beat only.
- R6: While `res_valid` is high and `res_ready` is low, the next cycle still shows `res_valid` high, with `res_data` and `res_last` unchanged.
- R7: In the cycle after the last beat transfers, `busy` and `res_valid` are low, and a new `start` is accepted at once.
- R8: Operands are captured on the edge that accepts `start`. Changing `op_a` or `op_b` afterwards does not affect the result.
- R9: `busy` is high from the cycle after an accepted `start` until the last beat has transferred, and it is high whenever `res_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when `busy` is low |
| op_a | input | OPW | Multiplier operand, consumed most significant bit first |
| op_b | input | OPW | Multiplicand operand |
| busy | output | 1 | Operation in progress or result not yet drained |
| done | output | 1 | One-cycle pulse when the product is complete |
| res_valid | output | 1 | Result stream beat available |
| res_ready | input | 1 | Sink accepts the current beat |
| res_data | output | 1 | Current product bit, least significant first |
| res_last | output | 1 | Marks the final (most significant) product bit |

## Verification
The bench attacks carry behaviour with all-ones operands. These drive a carry into every cell and fill the top half of the product. A design that dropped or mistimed the neighbour carry, or that read the neighbour's current bit instead of its previous one, would give a wrong upper half. Zero, one and single-high-bit operands exercise the digit ordering. A reversed digit order or a missing doubling shows up there as a mirrored or shifted product. Random sink stalls, stray `start` pulses during a run, and operands scrambled after capture target the stream hold rule, the ignore rule and the capture edge. A design that broke any of these would show a corrupted bit sequence, a restarted latency count or a product of the wrong operands.

// File: rtl/smul_pkg.sv
package smul_pkg;
  // token that walks up the cell chain, one register per cell
  typedef struct packed {
    logic vld;  // a digit step is present
    logic dig;  // the multiplier digit for this step
    logic lst;  // final digit (least significant) of the operand
  } wave_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_SEND = 2'd2
  } phase_t;
endpackage

// File: rtl/smul_cell.sv
module smul_cell
  import smul_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  wave_t tok_in,
  input  logic  b_bit,
  input  logic  p_in,
  input  logic  c_in,
  output wave_t tok_out,
  output logic  sum_o,
  output logic  shift_o,
  output logic  carry_o
);
  wave_t      tok_q;
  logic       sum_q;
  logic       shift_q;
  logic       carry_q;
  logic [1:0] add;

  // new bit = neighbour's previous bit (doubling) + digit*b + neighbour carry
  always_comb begin
    add = {1'b0, p_in} + {1'b0, tok_in.dig & b_bit} + {1'b0, c_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q   <= '0;
      sum_q   <= 1'b0;
      shift_q <= 1'b0;
      carry_q <= 1'b0;
    end else if (clr) begin
      tok_q   <= '0;
      sum_q   <= 1'b0;
      shift_q <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      tok_q <= tok_in;
      if (tok_in.vld) begin
        sum_q   <= add[0];
        carry_q <= add[1];
        shift_q <= sum_q;
      end
    end
  end

  assign tok_out = tok_q;
  assign sum_o   = sum_q;
  assign shift_o = shift_q;
  assign carry_o = carry_q;
endmodule

// File: rtl/smul_feed.sv
module smul_feed
  import smul_pkg::*;
#(
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [OPW-1:0] op_a,
  input  logic [OPW-1:0] op_b,
  input  wave_t          tail,
  input  logic           fin,
  output wave_t          head,
  output logic [OPW-1:0] b_hold,
  output logic           clr,
  output logic           cap,
  output logic           busy,
  output logic           done
);
  localparam int CW = $clog2(OPW + 1);

  phase_t         phase;
  logic [OPW-1:0] a_sh;
  logic [CW-1:0]  issued;
  logic           unused_tail_dig;

  assign unused_tail_dig = tail.dig;

  assign clr  = start && (phase == ST_IDLE);
  assign cap  = (phase == ST_RUN) && tail.vld && tail.lst;
  assign busy = (phase != ST_IDLE);

  always_comb begin
    head.vld = (phase == ST_RUN) && (issued < CW'(OPW));
    head.dig = a_sh[OPW-1];
    head.lst = (issued == CW'(OPW - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= ST_IDLE;
      a_sh   <= '0;
      b_hold <= '0;
      issued <= '0;
      done   <= 1'b0;
    end else begin
      done <= cap;
      case (phase)
        ST_IDLE: begin
          if (start) begin
            phase  <= ST_RUN;
            a_sh   <= op_a;
            b_hold <= op_b;
            issued <= '0;
          end
        end
        ST_RUN: begin
          if (head.vld) begin
            a_sh   <= a_sh << 1;
            issued <= issued + 1'b1;
          end
          if (cap) phase <= ST_SEND;
        end
        ST_SEND: begin
          if (fin) phase <= ST_IDLE;
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smul_ser.sv
module smul_ser #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] prod,
  input  logic         ready,
  output logic         valid,
  output logic         data,
  output logic         last,
  output logic         fin
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sh;
  logic [CW-1:0] left;

  assign valid = (left != '0);
  assign data  = sh[0];
  assign last  = (left == CW'(1));
  assign fin   = valid && ready && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
    end else if (cap) begin
      sh   <= prod;
      left <= CW'(W);
    end else if (valid && ready) begin
      sh   <= sh >> 1;
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/shiftadd_systolic_mul.sv
module shiftadd_systolic_mul #(
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [OPW-1:0] op_a,
  input  logic [OPW-1:0] op_b,
  output logic           busy,
  output logic           done,
  output logic           res_valid,
  input  logic           res_ready,
  output logic           res_data,
  output logic           res_last
);
  localparam int CELLS = 2 * OPW;

  smul_pkg::wave_t  wave [CELLS+1];
  logic [OPW-1:0]   b_hold;
  logic             clr;
  logic             cap;
  logic             fin;
  logic [CELLS-1:0] sum_v;
  logic [CELLS-1:0] shift_v;
  logic [CELLS-1:0] carry_v;
  logic             unused_top;

  // the top cell's forwarded bit and carry have no consumer
  assign unused_top = shift_v[CELLS-1] ^ carry_v[CELLS-1];

  smul_feed #(.OPW(OPW)) u_feed (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op_a   (op_a),
    .op_b   (op_b),
    .tail   (wave[CELLS]),
    .fin    (fin),
    .head   (wave[0]),
    .b_hold (b_hold),
    .clr    (clr),
    .cap    (cap),
    .busy   (busy),
    .done   (done)
  );

  generate
    for (genvar j = 0; j < CELLS; j++) begin : g_cell
      logic p_in;
      logic c_in;
      logic b_in;

      if (j == 0) begin : g_base
        assign p_in = 1'b0;
        assign c_in = 1'b0;
      end else begin : g_link
        assign p_in = shift_v[j-1];
        assign c_in = carry_v[j-1];
      end

      if (j < OPW) begin : g_mul
        assign b_in = b_hold[j];
      end else begin : g_ext
        assign b_in = 1'b0;
      end

      smul_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .tok_in  (wave[j]),
        .b_bit   (b_in),
        .p_in    (p_in),
        .c_in    (c_in),
        .tok_out (wave[j+1]),
        .sum_o   (sum_v[j]),
        .shift_o (shift_v[j]),
        .carry_o (carry_v[j])
      );
    end
  endgenerate

  smul_ser #(.W(CELLS)) u_ser (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (cap),
    .prod  (sum_v),
    .ready (res_ready),
    .valid (res_valid),
    .data  (res_data),
    .last  (res_last),
    .fin   (fin)
  );
endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
  parameter int OPW = 8
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic res_valid,
  input logic res_ready,
  input logic res_data,
  input logic res_last
);
  localparam int LAT = 3 * OPW;
  localparam int LW  = $clog2(LAT + 2);

  logic          trk;
  logic [LW-1:0] lat;

  // edges elapsed since the accepting edge (that edge counts as zero)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk <= 1'b0;
      lat <= '0;
    end else if (start && !busy) begin
      trk <= 1'b1;
      lat <= '0;
    end else if (trk) begin
      lat <= lat + 1'b1;
      if (done) trk <= 1'b0;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && !res_valid && !res_last));

  // also covers R4: a start while busy does not restart the count
  assert_done_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (trk && lat == LW'(LAT)));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_stream_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_valid);

  assert_last_in_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_last |-> res_valid);

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_last)));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && res_last) |=> (!busy && !res_valid));

  assert_busy_cover_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> busy);
endmodule

bind shiftadd_systolic_mul smul_chk #(.OPW(OPW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data),
  .res_last  (res_last)
);

// File: tb/sim_shiftadd_systolic_mul.sv
`timescale 1ns/1ps
module sim_shiftadd_systolic_mul;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         busy, done, res_valid, res_data, res_last;
  logic         res_ready = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  shiftadd_systolic_mul #(.OPW(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_last(res_last)
  );

  function automatic logic [2*W-1:0] ref_prod(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] xa, xb;
    xa = {{W{1'b0}}, a};
    xb = {{W{1'b0}}, b};
    return xa * xb;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mode 0: sink always ready; mode 1: random stalls. poke: stray starts + operand scramble
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input int mode, input bit poke);
    logic [2*W-1:0] exp_p, got;
    int  lat, beats, iter;
    bit  seen_last, bad_last, rdy, hold_chk, h_d, h_l;
    exp_p = ref_prod(a, b);
    op_a  = a;
    op_b  = b;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      op_a = ~a;              // R8: scramble after capture
      op_b = b ^ 8'h5A;
    end
    lat = 0;
    while (1) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (lat == 1) check(busy == 1'b1, "R9 busy after start", busy, 1);
      if (done || lat > 10 * W) break;
      if (poke && lat == 2) begin
        start = 1'b1;         // R4: must be ignored
        op_a  = W'($urandom);
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check(lat == 3 * W, poke ? "R4 latency with stray start" : "R3 done latency", lat, 3 * W);
    check(res_valid == 1'b1, "R5 stream opens with done", res_valid, 1);

    got = '0; beats = 0; iter = 0; seen_last = 0; bad_last = 0;
    while (!seen_last && iter < 40 * W) begin
      rdy = (mode == 0) ? 1'b1 : (($urandom % 3) != 0);
      res_ready = rdy;
      hold_chk = 0;
      if (res_valid && rdy) begin
        if (beats < 2 * W) got[beats] = res_data;
        beats++;
        if (res_last) seen_last = 1;
        if (res_last != (beats == 2 * W)) bad_last = 1;
      end else if (res_valid) begin
        hold_chk = 1;
        h_d = res_data;
        h_l = res_last;
      end
      @(posedge clk);
      @(negedge clk);
      if (iter == 0) check(done == 1'b0, "R3 done single cycle", done, 0);
      if (hold_chk)
        check(res_valid && res_data == h_d && res_last == h_l, "R6 stall hold",
              {res_valid, res_data, res_last}, {1'b1, h_d, h_l});
      iter++;
    end
    res_ready = 1'b0;
    check(beats == 2 * W, "R5 beat count", beats, 2 * W);
    check(!bad_last, "R5 last marks final beat", bad_last, 0);
    check(got == exp_p, poke ? "R8 product of captured operands" : "R2 product", got, exp_p);
    check(!busy && !res_valid, "R7 idle after last beat", {busy, res_valid}, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(!busy && !done && !res_valid && !res_last, "R1 reset state",
          {busy, done, res_valid, res_last}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !res_valid, "R1 after release", {busy, done, res_valid}, 0);

    // directed corners, back to back (R7: next start right after drain)
    run_op('0, '0, 0, 0);
    run_op('1, '1, 0, 0);
    run_op(W'(1), '1, 0, 0);
    run_op('1, W'(1), 1, 0);
    run_op({1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}}, 0, 0);
    run_op('0, W'(8'hA5), 1, 0);
    run_op(W'(8'h55), W'(8'hAA), 0, 1);
    run_op('1, '1, 1, 1);

    for (int k = 0; k < 40; k++)
      run_op(W'($urandom), W'($urandom), k % 2, (k % 3) == 0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule